// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that lets an external host reach a 64-byte register file through an internal register pointer. The SCL and SDA pins come in as plain inputs. SDA is driven open-drain through an output-enable that pulls the line low when set. A select pin picks the least significant bit of the 7-bit device address. Inside the chip, a local write port lets the sensor datapath update any register, including the data registers. Every byte that the host commits to the file is also presented on a one-cycle write strobe, so neighbouring logic can react to configuration writes.

A host transaction starts with the address byte. On a write, the byte after the address sets the register pointer, and any further bytes are stored at the pointer, which then steps by one. A random read writes the pointer, issues a repeated START and then reads. A current-address read skips the pointer write and starts wherever the pointer was left. A fast-read control bit in the file changes how read bursts step through the axis data. With the bit set, only the high byte of each axis is returned, and the burst then wraps back to the status register.

Both pins pass through a two-flop synchronizer, and every event is decoded from edges of the synchronized values. The system clock must run at least eight times the SCL rate.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), `host_wr_valid` is low and the register pointer is 0, so a current-address read with no pointer write returns register 0x00.
- R2: The target acknowledges device address 7'b0011100 when `addr_sel` = 0 and 7'b0011101 when `addr_sel` = 1. Any other address is not acknowledged. SDA then stays released, and later bytes have no effect until the next START.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START restarts address decoding without a STOP, and after a STOP, SDA is released.
- R4: In a write, the first byte after the address (R/W bit = 0) loads the pointer from its low 6 bits. Each later byte is acknowledged and stored at the pointer, and the pointer then steps by one, wrapping from 0x3F to 0x00.
- R5: In a read (R/W bit = 1), bytes are sent MSB first, starting at the pointer. The pointer is kept across a repeated START and between transactions.
- R6: During a read burst, the pointer advances after each byte that the host acknowledges. A byte that the host does not acknowledge ends the burst and leaves the pointer unchanged.
- R7: The fast-read control is bit 1 of register 0x2A. When it is set, a read burst steps 0x01→0x03→0x05→0x00, and all other addresses step by one. When it is clear, reads step by one. Writes always step by one.
- R8: Registers 0x00 to 0x0D are read-only to the host. A host write to one of them is acknowledged and discarded, and the pointer still advances.
- R9: The local port (`loc_we`) writes any register. Each host byte that is stored produces exactly one cycle of `host_wr_valid` with its address and data.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 (open-drain enable) |
| addr_sel | input | 1 | Selects the device address LSB |
| loc_we | input | 1 | Local register write enable |
| loc_addr | input | 6 | Local register write address |
| loc_wdata | input | 8 | Local register write data |
| host_wr_valid | output | 1 | One-cycle pulse for each stored host byte |
| host_wr_addr | output | 6 | Register address of the stored host byte |
| host_wr_data | output | 8 | Value of the stored host byte |

## Verification
The bench uses both address-select settings. It sends matching and non-matching addresses, so acknowledgement can be told apart from a line that stays released. Write bursts start at random pointers, some of them in the read-only range and some crossing the top of the file, which separates storing from discarding and shows the pointer wrap. Reads are tried three ways: random reads with a repeated START, current-address reads after earlier transfers, and bursts that end in a host NAK. Together these show whether the pointer is kept between transactions and whether it advances only on acknowledged bytes. Bursts starting at 0x01 are run with the fast-read bit both set and clear, which exposes the skipping step order.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } eng_state_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_PTR,
    RX_DATA
  } rx_kind_t;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rf_store.sv
module i2c_rf_store #(
  parameter int ADDR_W  = 6,
  parameter int FR_ADDR = 42,
  parameter int FR_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [7:0]        loc_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              fr_flag
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] FR_A = ADDR_W'(FR_ADDR);

  logic [7:0] mem [DEPTH];

  // Local write first, host write last: host wins on a same-cycle collision.
  always_ff @(posedge clk) begin
    if (loc_we)  mem[loc_addr]  <= loc_wdata;
    if (host_we) mem[host_addr] <= host_wdata;
    rd_data <= mem[rd_addr];
  end

  // Shadow copy of the fast-read control bit, same write priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      fr_flag <= 1'b0;
    end else if (host_we && host_addr == FR_A) begin
      fr_flag <= host_wdata[FR_BIT];
    end else if (loc_we && loc_addr == FR_A) begin
      fr_flag <= loc_wdata[FR_BIT];
    end
  end

endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = '0,
  parameter int FIRST_MSB = 1,
  parameter int AXES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [6:0]        dev_addr,
  input  logic              fr_flag,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);

  localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(FIRST_MSB);
  localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(FIRST_MSB + 2 * (AXES - 1));

  eng_state_t        state;
  rx_kind_t          kind;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [7:0]        txreg;
  logic [ADDR_W-1:0] ptr;
  logic              rw;
  logic              mack;

  logic [ADDR_W-1:0] offs;
  logic              skip;
  logic [ADDR_W-1:0] rd_next;

  // Read-burst pointer step, with the high-byte skip when fast-read is set.
  always_comb begin
    offs    = ptr - FIRST_A;
    skip    = fr_flag && (ptr >= FIRST_A) && (ptr <= LAST_A) && !offs[0];
    rd_next = ptr + 1'b1;
    if (skip) begin
      rd_next = (ptr == LAST_A) ? '0 : ptr + ADDR_W'(2);
    end
  end

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= RX_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      txreg   <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_RX;
        kind    <= RX_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              unique case (kind)
                RX_ADDR: begin
                  if (shreg[7:1] == dev_addr) begin
                    rw     <= shreg[0];
                    kind   <= RX_PTR;
                    sda_oe <= 1'b1;
                    state  <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                RX_PTR: begin
                  ptr    <= shreg[ADDR_W-1:0];
                  kind   <= RX_DATA;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
                default: begin
                  if (!RO_MASK[ptr]) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= shreg;
                  end
                  ptr    <= ptr + 1'b1;
                  sda_oe <= 1'b1;
                  state  <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                txreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                txreg   <= {txreg[6:0], 1'b0};
                sda_oe  <= ~txreg[6];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) ptr <= rd_next;
            end else if (scl_fall) begin
              if (mack) begin
                txreg   <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= '0;
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int ADDR_W      = 6,
  parameter logic [6:0] BASE_ADDR = 7'b0011100,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = {{((1<<ADDR_W)-14){1'b0}}, 14'h3FFF},
  parameter int FR_ADDR     = 42,
  parameter int FR_BIT      = 1,
  parameter int FIRST_MSB   = 1,
  parameter int AXES        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic              loc_we,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic [7:0]        loc_wdata,
  output logic              host_wr_valid,
  output logic [ADDR_W-1:0] host_wr_addr,
  output logic [7:0]        host_wr_data
);

  logic              scl_sync;
  logic              sda_sync;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_seen;
  logic [6:0]        dev_addr;
  logic              fr_flag;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] rd_addr;

  assign dev_addr = {BASE_ADDR[6:1], addr_sel};

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_sync),
    .sda_s     (sda_sync),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_seen)
  );

  i2c_rf_engine #(
    .ADDR_W    (ADDR_W),
    .RO_MASK   (RO_MASK),
    .FIRST_MSB (FIRST_MSB),
    .AXES      (AXES)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_seen),
    .sda_s     (sda_sync),
    .dev_addr  (dev_addr),
    .fr_flag   (fr_flag),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (host_wr_valid),
    .wr_addr   (host_wr_addr),
    .wr_data   (host_wr_data),
    .sda_oe    (sda_oe)
  );

  i2c_rf_store #(
    .ADDR_W  (ADDR_W),
    .FR_ADDR (FR_ADDR),
    .FR_BIT  (FR_BIT)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_wr_valid),
    .host_addr  (host_wr_addr),
    .host_wdata (host_wr_data),
    .loc_we     (loc_we),
    .loc_addr   (loc_addr),
    .loc_wdata  (loc_wdata),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .fr_flag    (fr_flag)
  );

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker #(
  parameter int ADDR_W = 6,
  parameter logic [(1<<ADDR_W)-1:0] RO_MASK = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_sync,
  input logic              stop_seen,
  input logic              sda_oe,
  input logic              host_wr_valid,
  input logic [ADDR_W-1:0] host_wr_addr
);

  // R1: reset leaves the line released and no strobe
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sda_oe && !host_wr_valid));

  // R3: a STOP releases SDA
  a_r3_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_seen |=> !sda_oe);

  // R8: no strobe ever targets a read-only register
  a_r8_no_ro_store: assert property (@(posedge clk) disable iff (rst)
    host_wr_valid |-> !RO_MASK[host_wr_addr]);

  // R9: each stored byte gives a single-cycle strobe
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    host_wr_valid |=> !host_wr_valid);

  // R10: the drive changes only while synchronized SCL is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_sync);

endmodule

bind i2c_regfile_target i2c_rf_checker #(
  .ADDR_W  (ADDR_W),
  .RO_MASK (RO_MASK)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_sync      (scl_sync),
  .stop_seen     (stop_seen),
  .sda_oe        (sda_oe),
  .host_wr_valid (host_wr_valid),
  .host_wr_addr  (host_wr_addr)
);

// File: tb/tb_i2c_regfile_target.sv
`timescale 1ns/1ps
module tb_i2c_regfile_target;

  localparam int Q = 8;  // SCL quarter period in system clocks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic addr_sel = 1'b0;
  logic loc_we = 1'b0;
  logic [5:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0;
  logic sda_oe;
  logic host_wr_valid;
  logic [5:0] host_wr_addr;
  logic [7:0] host_wr_data;
  wire  sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regfile_target dut (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (m_scl),
    .sda_i         (sda_line),
    .sda_oe        (sda_oe),
    .addr_sel      (addr_sel),
    .loc_we        (loc_we),
    .loc_addr      (loc_addr),
    .loc_wdata     (loc_wdata),
    .host_wr_valid (host_wr_valid),
    .host_wr_addr  (host_wr_addr),
    .host_wr_data  (host_wr_data)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] model [64];
  int mptr = 0;
  logic [7:0] wbuf [8];

  int strobe_cnt = 0;
  logic [5:0] last_waddr;
  logic [7:0] last_wdata;
  int oe_high_changes = 0;
  int oe_active_cnt = 0;
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst && host_wr_valid) begin
      strobe_cnt <= strobe_cnt + 1;
      last_waddr <= host_wr_addr;
      last_wdata <= host_wr_data;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe !== oe_prev && m_scl) oe_high_changes++;
      if (sda_oe) oe_active_cnt++;
    end
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit is_ro(input int a);
    return a <= 13;
  endfunction

  function automatic int next_read(input int p);
    if (model[42][1]) begin
      if (p == 1) return 3;
      if (p == 3) return 5;
      if (p == 5) return 0;
    end
    return (p + 1) % 64;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0;
    end
    wq();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_scl = 1'b1; wq();
      b[i] = sda_line;
      wq();
      m_scl = 1'b0; wq();
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic loc_write(input int a, input logic [7:0] d);
    @(negedge clk);
    loc_we = 1'b1; loc_addr = 6'(a); loc_wdata = d;
    @(negedge clk);
    loc_we = 1'b0;
    model[a] = d;
  endtask

  // R4 R8 R9: write burst of n bytes from wbuf starting at pointer p
  task automatic host_write(input int p, input int n);
    bit ack;
    int exp_strobes;
    int s0;
    int la;
    logic [7:0] ld;
    s0 = strobe_cnt;
    exp_strobes = 0;
    la = -1;
    ld = '0;
    bus_start();
    send_byte({6'b001110, addr_sel, 1'b0}, ack);
    check(ack, "R2 address ack", ack, 1);
    send_byte(8'(p), ack);
    check(ack, "R4 pointer ack", ack, 1);
    mptr = p;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ack);
      check(ack, is_ro(mptr) ? "R8 read-only byte ack" : "R4 data ack", ack, 1);
      if (!is_ro(mptr)) begin
        model[mptr] = wbuf[k];
        exp_strobes++;
        la = mptr;
        ld = wbuf[k];
      end
      mptr = (mptr + 1) % 64;
    end
    bus_stop();
    check(sda_oe == 1'b0, "R3 released after stop", sda_oe, 0);
    check(strobe_cnt - s0 == exp_strobes, "R9 strobe count", strobe_cnt - s0, exp_strobes);
    if (la >= 0) begin
      check(last_waddr == 6'(la) && last_wdata == ld, "R9 strobe addr/data",
            {last_waddr, last_wdata}, {la[5:0], ld});
    end
  endtask

  // R5 R6 R7: read n bytes, optionally after a pointer write and repeated START
  task automatic host_read(input bit set_ptr, input int p, input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({6'b001110, addr_sel, 1'b0}, ack);
      check(ack, "R2 address ack", ack, 1);
      send_byte(8'(p), ack);
      check(ack, "R4 pointer ack", ack, 1);
      mptr = p;
      bus_start();
    end
    send_byte({6'b001110, addr_sel, 1'b1}, ack);
    check(ack, "R3 read address ack after start", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      check(b == model[mptr], model[42][1] ? "R7 fast-read byte" : "R5 read byte",
            b, model[mptr]);
      if (k != n - 1) mptr = next_read(mptr);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    int seed_dummy;
    int oe0;
    seed_dummy = $urandom(32'h1C2A);
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(host_wr_valid == 1'b0, "R1 reset strobe", host_wr_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R9: local port loads every register, read-only ones included
    for (int a = 0; a < 64; a++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if (a == 42) v[1] = 1'b0;
      loc_write(a, v);
    end

    // R1: pointer starts at 0
    host_read(1'b0, 0, 1);

    // R4: burst write crossing the top of the file, then R5 random read
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h96;
    host_write(62, 3);
    check(mptr == 1, "R4 pointer wrap", mptr, 1);
    host_read(1'b1, 62, 3);
    // R5: current-address read continues where the last read stopped
    host_read(1'b0, 0, 2);

    // R8: write to read-only data register is discarded
    wbuf[0] = ~model[3]; wbuf[1] = ~model[4];
    host_write(3, 2);
    host_read(1'b1, 3, 2);

    // R2: non-matching address is ignored until the next START
    oe0 = oe_active_cnt;
    bus_start();
    send_byte(8'b0011101_0, ack);
    check(!ack, "R2 wrong address nak", ack, 0);
    send_byte(8'h20, ack);
    send_byte(8'h5A, ack);
    bus_stop();
    check(oe_active_cnt == oe0, "R2 line untouched", oe_active_cnt - oe0, 0);
    host_read(1'b0, 0, 1);  // pointer unaffected
    host_read(1'b1, 32, 1); // register unaffected

    // R2: select pin high moves the address
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'b0011100_0, ack);
    check(!ack, "R2 sel high rejects base", ack, 0);
    bus_stop();
    wbuf[0] = 8'h77;
    host_write(20, 1);
    host_read(1'b1, 20, 1);
    addr_sel = 1'b0;

    // R6: NAK ends a burst without advancing; next read repeats the byte
    host_read(1'b1, 40, 2);
    host_read(1'b0, 0, 1);

    // R7: fast-read skip order, then plain order
    wbuf[0] = model[42] | 8'h02;
    host_write(42, 1);
    host_read(1'b1, 1, 5);
    wbuf[0] = model[42] & 8'hFD;
    host_write(42, 1);
    host_read(1'b1, 1, 4);
    // R7: writes step by one with fast-read set
    wbuf[0] = model[42] | 8'h02;
    host_write(42, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    host_write(14, 2);
    check(mptr == 16, "R7 write step", mptr, 16);
    host_read(1'b1, 14, 2);
    wbuf[0] = model[42] & 8'hFD;
    host_write(42, 1);

    // Random mix of transactions
    for (int t = 0; t < 30; t++) begin
      int kind;
      int p;
      int n;
      kind = int'($urandom % 3);
      p = int'($urandom % 64);
      n = 1 + int'($urandom % 4);
      if (t == 10 || t == 20) begin
        wbuf[0] = model[42] ^ 8'h02;
        host_write(42, 1);
      end
      if (kind == 0) begin
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        host_write(p, n);
      end else if (kind == 1) begin
        host_read(1'b1, p, n);
      end else begin
        host_read(1'b0, 0, n);
      end
    end

    // R10: drive changes seen only while SCL low
    check(oe_high_changes == 0, "R10 oe change with scl high", oe_high_changes, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule